// File: doc/BRIEF.md
# Ring-Pair PUF Response Sequencer

This block turns frequency comparisons between pairs of free-running ring oscillators into a multi-bit device response. Each response bit comes from one pair of identically built rings. A challenge bit picks which ring of the pair feeds the first counter and which feeds the second. Both counters run over a fixed window of clock cycles. The bit is 1 only when the first count is strictly larger than the second.

The sequencer visits every ring pair in ascending order. It can repeat the whole sweep for up to `NUM_CFG` ring configurations, so the response is up to `NUM_PAIRS*NUM_CFG` bits wide. Before every measurement it sends a one-cycle load strobe with an initial-state pattern. The rings use this pattern to preset their stages. The pattern depends on the configuration number and on an operating-region index. This gives each temperature/voltage region its own set of ring setups.

The ring inputs are asynchronous. The selected pair passes through two-flop synchronisers and rising-edge detectors before it reaches the counters. The counters stop at their maximum value instead of wrapping, and any window that saturates a counter sets a sticky overflow flag.

The FSM states are IDLE, LOAD, COUNT, COMPARE and DONE. The transitions are:
- IDLE to LOAD on an accepted start.
- LOAD to COUNT after three cycles. This gives the synchronisers time to flush after the multiplexer changes.
- COUNT to COMPARE after `WINDOW` cycles.
- COMPARE to LOAD for the next pair, or COMPARE to DONE after the last pair of the last configuration.
- DONE to IDLE after one cycle.

`NUM_PAIRS` and `NUM_CFG` must be powers of two, each at least 2.

Top module: `ring_pair_puf_seq`

## Requirements
- R1: While reset is held and after it is released, with no start, `ring_load`, `done`, `overflow` and every bit of `response` are 0.
- R2: A start sampled in IDLE makes `ring_load` high for exactly one cycle in the next cycle. One measurement slot lasts `WINDOW+4` cycles, and `ring_load` pulses at the first cycle of every slot and at no other time.
- R3: For pair p, a challenge bit of 0 routes ring 2p to the first counter and ring 2p+1 to the second. A challenge bit of 1 swaps them. Challenge, `cfg_last` and `region` are captured when the start is accepted.
- R4: A response bit is 1 when the first window count is strictly greater than the second. Equal counts, including two saturated counts, give 0.
- R5: The bit measured for configuration c and pair p is stored at `response[c*NUM_PAIRS+p]`. Bits of configurations beyond `cfg_last` are 0.
- R6: A run covers configurations 0 to `cfg_last`. `done` is a one-cycle pulse in the cycle after the last comparison, that is `(cfg_last+1)*NUM_PAIRS*(WINDOW+4)` cycles after the first `ring_load`. `done` and `ring_load` are never high together.
- R7: While `ring_load` is high for configuration c, `ring_pattern` equals `PAT_SEED` rotated left (toward the MSB) by `(region*NUM_CFG + c) mod RING_LEN` bit positions.
- R8: Each counter stops at `2**CNT_W-1`. `overflow` is set after a window in which either counter reached that value, stays set for the rest of the run, and is cleared when the next start is accepted.
- R9: A start outside IDLE is ignored, including a start in the DONE cycle. `response` and `overflow` stay unchanged from `done` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a response run (accepted in IDLE only) |
| challenge | input | NUM_PAIRS | Per-pair swap bit for the counter multiplexers |
| cfg_last | input | $clog2(NUM_CFG) | Index of the last configuration to run |
| region | input | REG_W | Operating-region index that selects the pattern set |
| ring_osc | input | 2*NUM_PAIRS | Asynchronous ring outputs; pair p is rings 2p and 2p+1 |
| ring_load | output | 1 | One-cycle strobe to preset the rings |
| ring_pattern | output | RING_LEN | Ring stage preset values for the current configuration |
| response | output | NUM_PAIRS*NUM_CFG | Assembled response word |
| overflow | output | 1 | A counter saturated during this run |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Two functions can fall in the same cycle. The first case is the end of a run and a new start. The bench raises `start` exactly in the DONE cycle and expects it to be dropped: no `ring_load` follows, and the response stays unchanged. The second case is saturation of both counters in the same window, which meets the comparison rule. The bench drives both rings of pair 0 at the fastest possible rate, so both counts stop at the maximum. It then expects a 0 bit together with a set overflow flag. A behavioural model predicts `ring_load`, `ring_pattern` and `done` on every clock, and the response is computed from the ring periods the bench itself drives.

// File: rtl/puf_seq_pkg.sv
package puf_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_COUNT,
        S_COMPARE,
        S_DONE
    } seq_state_t;

    localparam int unsigned SETTLE_CYC = 3;
endpackage

// File: rtl/ring_edge_sync.sv
module ring_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         at_max
);
    assign at_max = &value;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               value <= '0;
        else if (clr)             value <= '0;
        else if (inc && !at_max)  value <= value + 1'b1;
    end
endmodule

// File: rtl/ring_select.sv
module ring_select #(
    parameter int unsigned NUM_PAIRS = 32,
    localparam int unsigned PAIR_W   = $clog2(NUM_PAIRS)
) (
    input  logic [2*NUM_PAIRS-1:0] rings,
    input  logic [PAIR_W-1:0]      pair,
    input  logic                   swap,
    output logic [1:0]             sel
);
    logic even_r, odd_r;

    always_comb begin
        even_r = rings[{pair, 1'b0}];
        odd_r  = rings[{pair, 1'b1}];
        sel[0] = swap ? odd_r  : even_r;
        sel[1] = swap ? even_r : odd_r;
    end
endmodule

// File: rtl/ring_pair_puf_seq.sv
module ring_pair_puf_seq
    import puf_seq_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = 32,
    parameter int unsigned NUM_CFG   = 4,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned WINDOW    = 1000,
    parameter int unsigned RING_LEN  = 8,
    parameter int unsigned REG_W     = 2,
    parameter logic [RING_LEN-1:0] PAT_SEED = 8'h2D,
    localparam int unsigned PAIR_W  = $clog2(NUM_PAIRS),
    localparam int unsigned CFG_W   = $clog2(NUM_CFG),
    localparam int unsigned RESP_W  = NUM_PAIRS * NUM_CFG,
    localparam int unsigned BIT_W   = PAIR_W + CFG_W,
    localparam int unsigned TMR_W   = $clog2(WINDOW + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [NUM_PAIRS-1:0]   challenge,
    input  logic [CFG_W-1:0]       cfg_last,
    input  logic [REG_W-1:0]       region,
    input  logic [2*NUM_PAIRS-1:0] ring_osc,
    output logic                   ring_load,
    output logic [RING_LEN-1:0]    ring_pattern,
    output logic [RESP_W-1:0]      response,
    output logic                   overflow,
    output logic                   done
);
    seq_state_t state_q, state_nx;

    logic [TMR_W-1:0]     tmr_q;
    logic [PAIR_W-1:0]    pair_q;
    logic [CFG_W-1:0]     cfg_q;
    logic [NUM_PAIRS-1:0] chal_q;
    logic [CFG_W-1:0]     cfg_last_q;
    logic [REG_W-1:0]     region_q;
    logic [RESP_W-1:0]    resp_q;
    logic                 ovf_q;

    logic [1:0]           sel;
    logic [1:0]           rise;
    logic [1:0]           at_max;
    logic [CNT_W-1:0]     cnt [2];
    logic [CNT_W-1:0]     cnt_a, cnt_b;
    logic                 last_slot;
    logic [BIT_W-1:0]     bit_idx;

    function automatic logic [RING_LEN-1:0] rot_left(input logic [RING_LEN-1:0] v,
                                                     input int n);
        return (v << n) | (v >> (RING_LEN - n));
    endfunction

    ring_select #(.NUM_PAIRS(NUM_PAIRS)) u_sel (
        .rings (ring_osc),
        .pair  (pair_q),
        .swap  (chal_q[pair_q]),
        .sel   (sel)
    );

    for (genvar g = 0; g < 2; g++) begin : g_lane
        ring_edge_sync u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (sel[g]),
            .rise     (rise[g])
        );
        sat_counter #(.W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (state_q == S_LOAD),
            .inc    ((state_q == S_COUNT) && rise[g]),
            .value  (cnt[g]),
            .at_max (at_max[g])
        );
    end

    assign cnt_a     = cnt[0];
    assign cnt_b     = cnt[1];
    assign last_slot = (pair_q == PAIR_W'(NUM_PAIRS - 1)) && (cfg_q == cfg_last_q);
    assign bit_idx   = {cfg_q, pair_q};

    // next-state decision
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_IDLE:    if (start) state_nx = S_LOAD;
            S_LOAD:    if (tmr_q == TMR_W'(SETTLE_CYC - 1)) state_nx = S_COUNT;
            S_COUNT:   if (tmr_q == TMR_W'(WINDOW - 1)) state_nx = S_COMPARE;
            S_COMPARE: state_nx = last_slot ? S_DONE : S_LOAD;
            S_DONE:    state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // state register and phase timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            tmr_q   <= '0;
        end else begin
            state_q <= state_nx;
            tmr_q   <= (state_nx != state_q) ? '0 : tmr_q + 1'b1;
        end
    end

    // run context, slot pointers and result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_q     <= '0;
            cfg_q      <= '0;
            chal_q     <= '0;
            cfg_last_q <= '0;
            region_q   <= '0;
            resp_q     <= '0;
            ovf_q      <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    chal_q     <= challenge;
                    cfg_last_q <= cfg_last;
                    region_q   <= region;
                    resp_q     <= '0;
                    ovf_q      <= 1'b0;
                    pair_q     <= '0;
                    cfg_q      <= '0;
                end
                S_COMPARE: begin
                    resp_q[bit_idx] <= (cnt_a > cnt_b);
                    ovf_q           <= ovf_q | (|at_max);
                    if (last_slot) begin
                        pair_q <= '0;
                        cfg_q  <= '0;
                    end else if (pair_q == PAIR_W'(NUM_PAIRS - 1)) begin
                        pair_q <= '0;
                        cfg_q  <= cfg_q + 1'b1;
                    end else begin
                        pair_q <= pair_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        ring_load    = (state_q == S_LOAD) && (tmr_q == '0);
        done         = (state_q == S_DONE);
        ring_pattern = rot_left(PAT_SEED,
                                (int'(region_q) * int'(NUM_CFG) + int'(cfg_q)) % int'(RING_LEN));
        response     = resp_q;
        overflow     = ovf_q;
    end
endmodule

// File: rtl/puf_seq_checker.sv
module puf_seq_checker #(
    parameter int unsigned RESP_W = 128,
    parameter int unsigned CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ring_load,
    input logic              done,
    input logic              overflow,
    input logic [RESP_W-1:0] response,
    input logic [CNT_W-1:0]  cnt_a,
    input logic [CNT_W-1:0]  cnt_b
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ring_load |=> !ring_load); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_LOAD_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ring_load |-> !done); // R6
    AST_RESP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(response)); // R9
    AST_OVF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(overflow)); // R8
    AST_SAT_A: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_a == MAXV) |=> (cnt_a == MAXV) || (cnt_a == '0)); // R8
    AST_SAT_B: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_b == MAXV) |=> (cnt_b == MAXV) || (cnt_b == '0)); // R8
endmodule

bind ring_pair_puf_seq puf_seq_checker #(.RESP_W(RESP_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring_load (ring_load),
    .done      (done),
    .overflow  (overflow),
    .response  (response),
    .cnt_a     (cnt_a),
    .cnt_b     (cnt_b)
);

// File: tb/test_ring_pair_puf_seq.sv
module test_ring_pair_puf_seq;
    localparam int NP   = 4;
    localparam int NC   = 4;
    localparam int CW   = 5;
    localparam int WIN  = 64;
    localparam int RL   = 8;
    localparam int RW   = 2;
    localparam int SLOT = WIN + 4;
    localparam logic [RL-1:0] SEED = 8'h2D;

    logic            clk = 0;
    logic            rst_n = 0;
    logic            start = 0;
    logic [NP-1:0]   challenge = '0;
    logic [1:0]      cfg_last = '0;
    logic [RW-1:0]   region = '0;
    logic [2*NP-1:0] ring_osc = '0;
    logic            ring_load, overflow, done;
    logic [RL-1:0]   ring_pattern;
    logic [NP*NC-1:0] response;

    int errors = 0, checks = 0, cyc = 0;
    bit fast = 0, finished = 0;

    // behavioural model state
    bit m_run = 0;
    int ph = 0, m_nb = 0, m_region = 0;
    logic [NP-1:0] m_chal = '0;

    ring_pair_puf_seq #(.NUM_PAIRS(NP), .NUM_CFG(NC), .CNT_W(CW), .WINDOW(WIN),
                        .RING_LEN(RL), .REG_W(RW), .PAT_SEED(SEED)) i_ring_pair_puf_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .challenge(challenge),
        .cfg_last(cfg_last), .region(region), .ring_osc(ring_osc),
        .ring_load(ring_load), .ring_pattern(ring_pattern), .response(response),
        .overflow(overflow), .done(done));

    always #5 clk = ~clk;

    function automatic int half_per(int k, int c);
        int kk = (k == 7) ? 6 : k;   // pair 3 rings identical: tie case
        if (fast && k < 2) return 1;
        return 2 + ((kk * 3 + c * 5) % 4);
    endfunction

    function automatic logic [RL-1:0] exp_pattern(int n);
        logic [RL-1:0] r;
        for (int i = 0; i < RL; i++) r[(i + n) % RL] = SEED[i];
        return r;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // model: advances at each clock edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) m_run = 0;
        else if (!m_run) begin
            if (start) begin
                m_run = 1; ph = 0; m_nb = (int'(cfg_last) + 1) * NP;
                m_region = int'(region); m_chal = challenge;
            end
        end else begin
            ph++;
            if (ph > m_nb * SLOT) m_run = 0;
        end
    end

    // ring stimulus, away from the active edge
    always @(negedge clk) begin
        int c;
        c = m_run ? (ph / SLOT) / NP : 0;
        if (c >= NC) c = NC - 1;
        for (int k = 0; k < 2 * NP; k++)
            ring_osc[k] = ((cyc / half_per(k, c)) % 2) != 0;
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            bit el, ed;
            el = m_run && (ph % SLOT == 0) && (ph < m_nb * SLOT);
            ed = m_run && (ph == m_nb * SLOT);
            check(ring_load == el, "R2", "ring_load", ring_load, el);
            check(done == ed, "R6", "done", done, ed);
            if (el) begin
                int n;
                n = (m_region * NC + (ph / SLOT) / NP) % RL;
                check(ring_pattern == exp_pattern(n), "R7", "ring_pattern",
                      ring_pattern, exp_pattern(n));
            end
        end
    end

    function automatic logic [NP*NC-1:0] exp_resp(logic [NP-1:0] ch, int ncfg);
        logic [NP*NC-1:0] r = '0;
        for (int c = 0; c < ncfg; c++)
            for (int p = 0; p < NP; p++) begin
                int a, b;
                a = ch[p] ? 2 * p + 1 : 2 * p;
                b = ch[p] ? 2 * p : 2 * p + 1;
                if (fast && p == 0) r[c * NP + p] = 1'b0;   // both saturate: tie
                else r[c * NP + p] = half_per(a, c) < half_per(b, c);
            end
        return r;
    endfunction

    task automatic run(logic [NP-1:0] ch, int cl, int rg, bit poke_done);
        logic [NP*NC-1:0] er;
        @(negedge clk);
        challenge = ch; cfg_last = 2'(cl); region = RW'(rg); start = 1;
        @(negedge clk);
        start = 0;
        challenge = ~ch;             // R3: later changes must not matter
        region = RW'(rg + 1);
        while (!(m_run && ph == m_nb * SLOT)) @(negedge clk);
        er = exp_resp(ch, cl + 1);
        for (int i = 0; i < NP * NC; i++) begin
            string rq;
            if (i >= (cl + 1) * NP) rq = "R5";
            else if ((i % NP) == 3 || (fast && (i % NP) == 0)) rq = "R4";
            else rq = "R3";
            check(response[i] == er[i], rq, $sformatf("response bit %0d", i), response[i], er[i]);
        end
        check(response == er, "R5", "response word", response, er);
        check(overflow == fast, "R8", "overflow", overflow, fast);
        if (poke_done) begin
            start = 1;               // start during DONE: ignored
            @(negedge clk);
            start = 0;
        end
        repeat (5) @(negedge clk);
        check(response == er, "R9", "response held", response, er);
        check(overflow == fast, "R9", "overflow held", overflow, fast);
        check(!ring_load && !done, "R9", "idle after run", {ring_load, done}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(response == '0 && !ring_load && !done && !overflow, "R1", "in reset",
              {response, ring_load, done, overflow}, 0);
        rst_n = 1;
        repeat (4) @(negedge clk);
        check(response == '0 && !ring_load && !done && !overflow, "R1", "after reset",
              {response, ring_load, done, overflow}, 0);
        run(4'b0101, 3, 1, 0);       // four configurations, region 1
        run(4'b1010, 1, 3, 1);       // two configurations, start during DONE
        fast = 1;
        run(4'b0011, 0, 2, 0);       // saturation on pair 0, one configuration
        fast = 0;
        run(4'b0110, 2, 0, 0);       // overflow cleared by new start
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule